// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small status word that tells software which reset source caused the most recent reset. It watches four sources: the power-on reset, the external reset pin, the watchdog and the brown-out detector. Each has its own cause bit. The register sits in the power-on reset domain, so its contents survive every other kind of reset and can be read once the processor restarts.

A power-on reset loads the word with only the power-on bit set. Any other source that is still asserted when power-on reset is released is recorded next to it. Each of the other sources sets only its own bit and leaves the rest alone. Software clears bits by writing ones; zeros in a write change nothing. The read port returns the cause bits zero-extended to the data width.

Top module: `rst_cause_reg`

## Requirements
- R1: While `por_n` is low at a clock edge, the register becomes 0x01 on that edge. Bit 0 (power-on) is set and bits 1 to 3 are cleared.
- R2: When `ext_rst_i` is high at an edge where `por_n` is high, bit 1 is set after that edge.
- R3: When `wdt_rst_i` is high at an edge where `por_n` is high, bit 2 is set after that edge.
- R4: When `bod_rst_i` is high at an edge where `por_n` is high, bit 3 is set after that edge.
- R5: A source that is still high on the first edge after `por_n` rises is recorded together with bit 0.
- R6: Bit 0 is never set or cleared by the external, watchdog or brown-out inputs.
- R7: Each of bits 1 to 3 is left unchanged by the other two non-power-on sources.
- R8: On an edge where `wr_en_i` is high, every cause bit whose matching `wr_data_i` bit is 1 is cleared. Every bit whose matching `wr_data_i` bit is 0 keeps its value.
- R9: If a source is high on the same edge as a write that clears its bit, the bit ends up set.
- R10: Bits of `rd_data_o` from position 4 upward always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| ext_rst_i | input | 1 | External reset pin level, active high |
| wdt_rst_i | input | 1 | Watchdog reset level, active high |
| bod_rst_i | input | 1 | Brown-out reset level, active high |
| wr_en_i | input | 1 | Write strobe for the clear operation |
| wr_data_i | input | DATA_W | Write data; a 1 clears the matching cause bit |
| rd_data_o | output | DATA_W | Cause bits, zero-extended |

## Verification
The assertions assume that the three source levels and the write port are already synchronous to `clk`. They also assume that `por_n` is driven low from time zero. Under these conditions a source seen high at an edge must show its bit on the next cycle. The bench meets this by changing every input only on the falling edge and by holding `por_n` low for the first cycles. It then mixes directed cases (release of power-on with a source held high, a set and a clear on the same edge, writes to the upper bits) with a long run of pseudo-random source and write patterns.

// File: rtl/rst_cause_pkg.sv
// Package: shared bit positions of the reset cause register.
// Assumes: the power-on bit is always position 0 and the other sources follow in order.
package rst_cause_pkg;
    localparam int NUM_SRC   = 3;            // non power-on sources
    localparam int CAUSE_W   = NUM_SRC + 1;  // cause bits incl. power-on
    localparam int POS_POR   = 0;
    localparam int POS_EXT   = 1;
    localparam int POS_WDT   = 2;
    localparam int POS_BOD   = 3;
endpackage

// File: rtl/rst_cause_bit.sv
// Module: one sticky cause bit with set-priority over write-one-to-clear.
// Assumes: src_i and clr_i are synchronous to clk; por_n is a synchronous active-low reset.
module rst_cause_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic src_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_r;

    // Sticky flag: reset value on power-on, set by source, cleared by software.
    always_ff @(posedge clk) begin
        if (!por_n)
            q_r <= RST_VAL;
        else if (src_i)
            q_r <= 1'b1;
        else if (clr_i)
            q_r <= 1'b0;
    end

    assign q_o = q_r;

    // R2 R3 R4 R9
    src_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
        src_i |=> q_o);

    // R8
    clr_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clr_i && !src_i) |=> !q_o);

    // R6 R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!clr_i && !src_i) |=> $stable(q_o));
endmodule

// File: rtl/rst_cause_reg.sv
// Module: reset cause status register in the power-on domain.
// Assumes: source levels and the write port are synchronous to clk; DATA_W >= CAUSE_W.
module rst_cause_reg
    import rst_cause_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_i,
    input  logic              wdt_rst_i,
    input  logic              bod_rst_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int PAD_W = DATA_W - CAUSE_W;

    logic [CAUSE_W-1:0] src_vec;
    logic [CAUSE_W-1:0] clr_vec;
    logic [CAUSE_W-1:0] cause_q;

    // Collect the source levels; power-on has no set input of its own.
    always_comb begin
        src_vec          = '0;
        src_vec[POS_EXT] = ext_rst_i;
        src_vec[POS_WDT] = wdt_rst_i;
        src_vec[POS_BOD] = bod_rst_i;
    end

    // Clear request per bit from a write of ones.
    assign clr_vec = wr_en_i ? wr_data_i[CAUSE_W-1:0] : '0;

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
        rst_cause_bit #(
            .RST_VAL(i == POS_POR)
        ) u_bit (
            .clk  (clk),
            .por_n(por_n),
            .src_i(src_vec[i]),
            .clr_i(clr_vec[i]),
            .q_o  (cause_q[i])
        );
    end

    // R10: pad upper bits with zero
    if (PAD_W > 0) begin : g_pad
        assign rd_data_o = {{PAD_W{1'b0}}, cause_q};
    end else begin : g_nopad
        assign rd_data_o = cause_q;
    end

    // R1
    por_state_chk: assert property (@(posedge clk)
        !por_n |=> (cause_q == CAUSE_W'(1)));

    // R5
    por_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(por_n) && ext_rst_i) |=> (rd_data_o[POS_EXT] && rd_data_o[POS_POR]));
endmodule

// File: tb/rst_cause_reg_tb_top.sv
// Bench: behavioural model of the cause word compared on every falling edge.
module rst_cause_reg_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          ext_rst = 1'b0, wdt_rst = 1'b0, bod_rst = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;

    int    n_vec = 0, n_fail = 0;
    string cur_req = "R1";
    logic [3:0] model = 4'h0;
    logic  model_valid = 1'b0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    rst_cause_reg #(.DATA_W(DW)) dut_i (
        .clk(clk), .por_n(por_n), .ext_rst_i(ext_rst), .wdt_rst_i(wdt_rst),
        .bod_rst_i(bod_rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data)
    );

    // Reference: what each edge must do to the cause word.
    always @(posedge clk) begin
        logic [3:0] nx;
        nx = model;
        if (!por_n) nx = 4'b0001;
        else begin
            if (wr_en) nx = nx & ~wr_data[3:0];
            if (ext_rst) nx[1] = 1'b1;
            if (wdt_rst) nx[2] = 1'b1;
            if (bod_rst) nx[3] = 1'b1;
        end
        model <= nx;
        model_valid <= 1'b1;
    end

    // Compare on each falling edge.
    always @(negedge clk) begin
        if (model_valid && !done) begin
            n_vec++;
            if (rd_data !== {4'h0, model}) begin
                n_fail++;
                $display("FAIL %s: rd_data=%h expected=%h", cur_req, rd_data, {4'h0, model});
            end
        end
    end

    task automatic step(input logic p, input logic e, input logic w, input logic b,
                        input logic we, input logic [DW-1:0] wd);
        @(negedge clk);
        #0.5;
        por_n = p; ext_rst = e; wdt_rst = w; bod_rst = b; wr_en = we; wr_data = wd;
    endtask

    initial begin
        logic [15:0] lfsr;
        cur_req = "R1";
        repeat (3) step(0, 0, 0, 0, 0, 8'h00);
        cur_req = "R5";
        step(0, 1, 0, 0, 0, 8'h00);
        step(1, 1, 0, 0, 0, 8'h00);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R8";
        step(1, 0, 0, 0, 1, 8'h02);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R3";
        step(1, 0, 1, 0, 0, 8'h00);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R4";
        step(1, 0, 0, 1, 0, 8'h00);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R2";
        step(1, 1, 0, 0, 0, 8'h00);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R8";
        step(1, 0, 0, 0, 1, 8'h00);
        step(1, 0, 0, 0, 1, 8'h05);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R9";
        step(1, 0, 1, 0, 1, 8'h0F);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R10";
        step(1, 0, 0, 0, 1, 8'hF0);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R6";
        step(1, 1, 1, 1, 0, 8'h00);
        step(1, 0, 0, 0, 1, 8'h0E);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R7";
        step(1, 0, 1, 0, 0, 8'h00);
        step(1, 0, 0, 0, 1, 8'h04);
        step(1, 0, 0, 1, 0, 8'h00);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R1";
        step(0, 0, 1, 1, 0, 8'h00);
        step(0, 1, 0, 0, 1, 8'h0F);
        cur_req = "R5";
        step(1, 0, 1, 0, 0, 8'h00);
        step(1, 0, 0, 0, 0, 8'h00);
        cur_req = "R6 R7 R8";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[15:2] != 0, lfsr[0] & lfsr[5], lfsr[1] & lfsr[6], lfsr[2] & lfsr[7],
                 lfsr[3], lfsr[15:8]);
        end
        step(1, 0, 0, 0, 0, 8'h00);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule